// File: doc/BRIEF.md
# Dual-Mode Translation Buffer with Side-Effect Invalidation

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KB pages. It keeps two independent direct-mapped buffers, one for supervisor space and one for user space. Each access presents a virtual address, a mode bit and a write flag. The block answers in the same cycle with a hit, or with a miss that asks an external table walker for the translation. On a hit it returns the physical frame number, the read-only flag and the cache-inhibit flag. The walker writes its results back through a fill port.

Software controls invalidation through side effects of register accesses, not through explicit commands. A full-width read of the buffer control register flushes both buffers. Writing one of two particular values to that register flushes one buffer. Writing either table root pointer flushes the buffer of its mode. A write in the purge address space removes the translation for one page from both buffers at once. The two root pointers are held here and offered to the walker.

Top module: `tlb_dual_mode`

## Requirements
- R1: Each buffer has 2^IDX_W entries (1024 by default). An entry is indexed by VA[21:12] and tagged by VA[31:22]. A lookup uses only the buffer picked by `lk_super` (1 = supervisor). A hit returns the stored frame, read-only flag and cache-inhibit flag. A valid entry with another tag at the same index gives a miss.
- R2: `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low. With `lk_valid` low, both outputs are low.
- R3: A write lookup (`lk_write`=1) that finds an entry whose modify state is clear reports a miss. The same entry hits for reads, and it hits for writes once it is filled with the modify state set.
- R4: A fill writes tag, frame, read-only, cache-inhibit and modify state into the buffer picked by `fill_super`. The entry can be looked up from the next cycle on.
- R5: Register select encoding: 0 = supervisor root, 1 = user root, 2 = buffer control, 3 = none. A read of the control register with `reg_long`=1 invalidates every entry of both buffers. A read with `reg_long`=0 has no effect.
- R6: A write to the control register with `reg_long`=1 and data 32'h0000_0000 invalidates only the user buffer. Data 32'h0000_8000 invalidates only the supervisor buffer. Any other data, and any write with `reg_long`=0, has no effect.
- R7: Any write to select 0 or 1 loads `reg_wdata[19:0]` into `sup_root` or `usr_root`, visible from the next cycle. The same write invalidates the buffer of that mode.
- R8: A cycle with `purge_wr` high invalidates the entry for the page of `purge_va` in both buffers. An entry at the same index with another tag stays valid.
- R9: A lookup in the same cycle as an invalidation that covers it reports a miss. A fill in the same cycle as an invalidation of its buffer, or as a purge of its page, leaves no valid entry.
- R10: After reset, every lookup misses and both root pointers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_super | input | 1 | Lookup mode, 1 = supervisor |
| lk_write | input | 1 | Lookup is for a write |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Walk request |
| lk_pfn | output | 20 | Physical frame number on hit |
| lk_ro | output | 1 | Page is read-only |
| lk_ci | output | 1 | Page is not cacheable |
| fill_en | input | 1 | Write a walked translation |
| fill_super | input | 1 | Fill target buffer, 1 = supervisor |
| fill_va | input | 32 | Virtual address of the fill |
| fill_pfn | input | 20 | Frame number to store |
| fill_ro | input | 1 | Read-only attribute to store |
| fill_ci | input | 1 | Cache-inhibit attribute to store |
| fill_mod | input | 1 | Modify state to store |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_long | input | 1 | Access is full 32-bit width |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| purge_wr | input | 1 | Write in purge address space |
| purge_va | input | 32 | Address to purge |
| sup_root | output | 20 | Supervisor table root frame |
| usr_root | output | 20 | User table root frame |

## Verification
A lookup and an invalidation can share a cycle. So can a fill and an invalidation. The bench applies a control read, a control write, a root write or a purge while a lookup of a covered page sits on the inputs in the same cycle, and expects a miss in that cycle. It also applies a fill together with a flush of its buffer, or with a purge of the same page, and expects the page to miss on the following cycle.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int PFN_W   = VA_W - PG_BITS;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             ro;
        logic             ci;
        logic             mod;
    } tlbm_attr_t;

    typedef enum logic [1:0] {
        SEL_SUP_ROOT = 2'd0,
        SEL_USR_ROOT = 2'd1,
        SEL_TLB_CTL  = 2'd2,
        SEL_NONE     = 2'd3
    } tlbm_sel_e;

    localparam logic [31:0] CTL_FLUSH_USR = 32'h0000_0000;
    localparam logic [31:0] CTL_FLUSH_SUP = 32'h0000_8000;

    function automatic logic [PFN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:PG_BITS];
    endfunction
endpackage

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
    import tlbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_long,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic             kill_sup,
    output logic             kill_usr,
    output logic [PFN_W-1:0] sup_root,
    output logic [PFN_W-1:0] usr_root
);
    tlbm_sel_e sel;
    logic ctl_hit, rd_flush_all, wr_flush_usr, wr_flush_sup, sup_ld, usr_ld;

    assign sel          = tlbm_sel_e'(reg_sel);
    assign ctl_hit      = (sel == SEL_TLB_CTL);
    assign rd_flush_all = reg_rd && reg_long && ctl_hit;
    assign wr_flush_usr = reg_wr && reg_long && ctl_hit && (reg_wdata == CTL_FLUSH_USR);
    assign wr_flush_sup = reg_wr && reg_long && ctl_hit && (reg_wdata == CTL_FLUSH_SUP);
    assign sup_ld       = reg_wr && (sel == SEL_SUP_ROOT);
    assign usr_ld       = reg_wr && (sel == SEL_USR_ROOT);

    assign kill_sup = rd_flush_all || wr_flush_sup || sup_ld;
    assign kill_usr = rd_flush_all || wr_flush_usr || usr_ld;

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_root <= '0;
            usr_root <= '0;
        end else begin
            if (sup_ld) sup_root <= reg_wdata[PFN_W-1:0];
            if (usr_ld) usr_root <= reg_wdata[PFN_W-1:0];
        end
    end

    // R7
    sup_root_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0) |=> sup_root == $past(reg_wdata[PFN_W-1:0]));
    // R7
    usr_root_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd1) |=> usr_root == $past(reg_wdata[PFN_W-1:0]));
endmodule

// File: rtl/tlbm_bank.sv
module tlbm_bank
    import tlbm_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill_all,
    input  logic             pg_en,
    input  logic [PFN_W-1:0] pg_vpn,
    input  logic             fill_en,
    input  logic [PFN_W-1:0] fill_vpn,
    input  tlbm_attr_t       fill_attr,
    input  logic [PFN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlbm_attr_t       lk_attr
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PFN_W - IDX_W;

    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    tlbm_attr_t       attr_q [DEPTH];

    logic [IDX_W-1:0] pg_idx, f_idx, l_idx;
    logic [TAG_W-1:0] pg_tag, f_tag, l_tag;
    logic             pg_match, fill_purged, lk_purged;

    assign pg_idx = pg_vpn[IDX_W-1:0];
    assign pg_tag = pg_vpn[PFN_W-1:IDX_W];
    assign f_idx  = fill_vpn[IDX_W-1:0];
    assign f_tag  = fill_vpn[PFN_W-1:IDX_W];
    assign l_idx  = lk_vpn[IDX_W-1:0];
    assign l_tag  = lk_vpn[PFN_W-1:IDX_W];

    assign pg_match    = pg_en && vld[pg_idx] && (tag_q[pg_idx] == pg_tag);
    assign fill_purged = pg_en && (pg_vpn == fill_vpn);
    assign lk_purged   = pg_en && (pg_vpn == lk_vpn);

    always_ff @(posedge clk) begin
        if (rst || kill_all) begin
            vld <= '0;
        end else begin
            if (pg_match) vld[pg_idx] <= 1'b0;
            if (fill_en)  vld[f_idx]  <= !fill_purged;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[f_idx]  <= f_tag;
            attr_q[f_idx] <= fill_attr;
        end
    end

    assign lk_hit  = vld[l_idx] && (tag_q[l_idx] == l_tag) && !kill_all && !lk_purged;
    assign lk_attr = attr_q[l_idx];

    // R5 R6 R7
    bulk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kill_all |=> (vld == '0));
    // R8
    purge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pg_match && !(fill_en && f_idx == pg_idx)) |=> !vld[$past(pg_idx)]);
    // R4
    fill_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !kill_all && !fill_purged) |=> vld[$past(f_idx)]);
endmodule

// File: rtl/tlb_dual_mode.sv
module tlb_dual_mode
    import tlbm_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_super,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_ro,
    output logic             lk_ci,
    input  logic             fill_en,
    input  logic             fill_super,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_ro,
    input  logic             fill_ci,
    input  logic             fill_mod,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_long,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             purge_wr,
    input  logic [VA_W-1:0]  purge_va,
    output logic [PFN_W-1:0] sup_root,
    output logic [PFN_W-1:0] usr_root
);
    localparam int NBANK = 2;

    logic             kill_sup, kill_usr;
    logic [NBANK-1:0] kill_v, fill_sel, hit_v;
    tlbm_attr_t       attr_v [NBANK];
    tlbm_attr_t       fill_attr, sel_attr;
    logic             raw_hit;
    logic             unused_offsets;

    assign unused_offsets = ^{lk_va[PG_BITS-1:0], fill_va[PG_BITS-1:0], purge_va[PG_BITS-1:0]};

    tlbm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_long (reg_long),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .kill_sup (kill_sup),
        .kill_usr (kill_usr),
        .sup_root (sup_root),
        .usr_root (usr_root)
    );

    assign kill_v    = {kill_sup, kill_usr};
    assign fill_sel  = {fill_super, !fill_super};
    assign fill_attr = '{pfn: fill_pfn, ro: fill_ro, ci: fill_ci, mod: fill_mod};

    // bank 0 = user space, bank 1 = supervisor space
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        tlbm_bank #(.IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .kill_all (kill_v[g]),
            .pg_en    (purge_wr),
            .pg_vpn   (vpn_of(purge_va)),
            .fill_en  (fill_en && fill_sel[g]),
            .fill_vpn (vpn_of(fill_va)),
            .fill_attr(fill_attr),
            .lk_vpn   (vpn_of(lk_va)),
            .lk_hit   (hit_v[g]),
            .lk_attr  (attr_v[g])
        );
    end

    assign raw_hit  = hit_v[lk_super];
    assign sel_attr = attr_v[lk_super];

    assign lk_hit  = lk_valid && raw_hit && !(lk_write && !sel_attr.mod);
    assign lk_miss = lk_valid && !lk_hit;
    assign lk_pfn  = sel_attr.pfn;
    assign lk_ro   = sel_attr.ro;
    assign lk_ci   = sel_attr.ci;

    // R2
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit != lk_miss));
    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss));
    // R9
    flush_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ((lk_super && kill_sup) || (!lk_super && kill_usr))) |-> !lk_hit);
endmodule

// File: tb/tlb_dual_mode_bench.sv
`timescale 1ns/10ps
module tlb_dual_mode_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_super, lk_write;
    logic [31:0] lk_va;
    logic        lk_hit, lk_miss, lk_ro, lk_ci;
    logic [19:0] lk_pfn;
    logic        fill_en, fill_super, fill_ro, fill_ci, fill_mod;
    logic [31:0] fill_va;
    logic [19:0] fill_pfn;
    logic        reg_rd, reg_wr, reg_long;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        purge_wr;
    logic [31:0] purge_va;
    logic [19:0] sup_root, usr_root;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [31:0] VA_A  = 32'h0040_3000; // idx 3, tag 1
    localparam logic [31:0] VA_A2 = 32'h0080_3000; // idx 3, tag 2
    localparam logic [31:0] VA_B  = 32'h1234_5000;

    always #2.5 clk = ~clk;

    tlb_dual_mode u_tlb_dual_mode (.*);

    task automatic clr();
        lk_valid = 0; lk_super = 0; lk_write = 0; lk_va = '0;
        fill_en = 0; fill_super = 0; fill_va = '0; fill_pfn = '0;
        fill_ro = 0; fill_ci = 0; fill_mod = 0;
        reg_rd = 0; reg_wr = 0; reg_long = 0; reg_sel = 2'd3; reg_wdata = '0;
        purge_wr = 0; purge_va = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
        clr();
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // lookup inside the current cycle; exp_hit=0 means a miss is expected
    task automatic look(input string req, input bit sup, input bit wr, input logic [31:0] va,
                        input bit exp_hit, input logic [19:0] pfn, input bit ro, input bit ci);
        lk_valid = 1; lk_super = sup; lk_write = wr; lk_va = va;
        #0.1;
        if (exp_hit)
            chk(req, "lookup", {8'h0, lk_pfn, lk_ro, lk_ci, lk_hit, lk_miss},
                {8'h0, pfn, ro, ci, 1'b1, 1'b0});
        else
            chk(req, "lookup", {30'h0, lk_hit, lk_miss}, {30'h0, 2'b01});
    endtask

    task automatic fill(input bit sup, input logic [31:0] va, input logic [19:0] pfn,
                        input bit ro, input bit ci, input bit md);
        fill_en = 1; fill_super = sup; fill_va = va; fill_pfn = pfn;
        fill_ro = ro; fill_ci = ci; fill_mod = md;
    endtask

    task automatic t_reset();
        cyc();
        look("R10", 1, 0, VA_A, 0, '0, 0, 0);
        look("R10", 0, 0, VA_B, 0, '0, 0, 0);
        chk("R10", "sup_root", {12'h0, sup_root}, 32'h0);
        chk("R10", "usr_root", {12'h0, usr_root}, 32'h0);
    endtask

    task automatic fill_both();
        cyc(); fill(1, VA_A, 20'hABCDE, 1, 0, 1);
        cyc(); fill(0, VA_A, 20'h12345, 0, 1, 1);
    endtask

    task automatic t_fill_lookup();
        fill_both();
        cyc();
        look("R1", 1, 0, VA_A, 1, 20'hABCDE, 1, 0);
        look("R1", 0, 0, VA_A, 1, 20'h12345, 0, 1);
        look("R1", 0, 0, VA_A2, 0, '0, 0, 0);
        look("R4", 1, 0, VA_B, 0, '0, 0, 0);
        lk_valid = 0; #0.1;
        chk("R2", "idle outputs", {30'h0, lk_hit, lk_miss}, 32'h0);
    endtask

    task automatic t_modify();
        cyc(); fill(0, VA_B, 20'h0BEEF, 0, 0, 0);
        cyc();
        look("R3", 0, 0, VA_B, 1, 20'h0BEEF, 0, 0);
        look("R3", 0, 1, VA_B, 0, '0, 0, 0);
        fill(0, VA_B, 20'h0BEEF, 0, 0, 1);
        cyc();
        look("R3", 0, 1, VA_B, 1, 20'h0BEEF, 0, 0);
    endtask

    task automatic t_ctl_writes();
        fill_both();
        cyc(); reg_wr = 1; reg_long = 1; reg_sel = 2'd2; reg_wdata = 32'h0000_1234;
        cyc(); reg_wr = 1; reg_long = 0; reg_sel = 2'd2; reg_wdata = 32'h0;
        cyc();
        look("R6", 0, 0, VA_A, 1, 20'h12345, 0, 1);
        look("R6", 1, 0, VA_A, 1, 20'hABCDE, 1, 0);
        reg_wr = 1; reg_long = 1; reg_sel = 2'd2; reg_wdata = 32'h0;
        look("R9", 0, 0, VA_A, 0, '0, 0, 0);
        cyc();
        look("R6", 0, 0, VA_A, 0, '0, 0, 0);
        look("R6", 1, 0, VA_A, 1, 20'hABCDE, 1, 0);
        fill(0, VA_A, 20'h12345, 0, 1, 1);
        cyc(); reg_wr = 1; reg_long = 1; reg_sel = 2'd2; reg_wdata = 32'h0000_8000;
        cyc();
        look("R6", 1, 0, VA_A, 0, '0, 0, 0);
        look("R6", 0, 0, VA_A, 1, 20'h12345, 0, 1);
    endtask

    task automatic t_ctl_read();
        fill_both();
        cyc(); reg_rd = 1; reg_long = 0; reg_sel = 2'd2;
        cyc();
        look("R5", 1, 0, VA_A, 1, 20'hABCDE, 1, 0);
        reg_rd = 1; reg_long = 1; reg_sel = 2'd2;
        look("R9", 0, 0, VA_A, 0, '0, 0, 0);
        cyc();
        look("R5", 1, 0, VA_A, 0, '0, 0, 0);
        look("R5", 0, 0, VA_A, 0, '0, 0, 0);
        // fill into a buffer that is flushed in the same cycle
        fill(1, VA_B, 20'h00042, 0, 0, 1);
        reg_rd = 1; reg_long = 1; reg_sel = 2'd2;
        cyc();
        look("R9", 1, 0, VA_B, 0, '0, 0, 0);
    endtask

    task automatic t_roots();
        fill_both();
        cyc(); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 32'hFFF4_5678;
        cyc();
        chk("R7", "usr_root", {12'h0, usr_root}, 32'h0004_5678);
        look("R7", 0, 0, VA_A, 0, '0, 0, 0);
        look("R7", 1, 0, VA_A, 1, 20'hABCDE, 1, 0);
        reg_wr = 1; reg_sel = 2'd0; reg_long = 0; reg_wdata = 32'h0000_9ABC;
        cyc();
        chk("R7", "sup_root", {12'h0, sup_root}, 32'h0000_9ABC);
        chk("R7", "usr_root kept", {12'h0, usr_root}, 32'h0004_5678);
        look("R7", 1, 0, VA_A, 0, '0, 0, 0);
    endtask

    task automatic t_purge();
        cyc(); fill(0, VA_A, 20'h11111, 0, 0, 1);
        cyc(); fill(1, VA_A2, 20'h22222, 1, 1, 1);
        cyc(); purge_wr = 1; purge_va = VA_A;
        look("R9", 0, 0, VA_A, 0, '0, 0, 0);
        cyc();
        look("R8", 0, 0, VA_A, 0, '0, 0, 0);
        look("R8", 1, 0, VA_A2, 1, 20'h22222, 1, 1);
        fill(1, VA_A, 20'h33333, 0, 0, 1);
        cyc(); fill(0, VA_A, 20'h44444, 0, 0, 1);
        cyc(); purge_wr = 1; purge_va = VA_A;
        cyc();
        look("R8", 1, 0, VA_A, 0, '0, 0, 0);
        look("R8", 0, 0, VA_A, 0, '0, 0, 0);
        fill(0, VA_B, 20'h55555, 0, 0, 1);
        purge_wr = 1; purge_va = VA_B;
        cyc();
        look("R9", 0, 0, VA_B, 0, '0, 0, 0);
    endtask

    initial begin
        clr();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_fill_lookup();
        t_modify();
        t_ctl_writes();
        t_ctl_read();
        t_roots();
        t_purge();
        cyc();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule